// File: doc/BRIEF.md
# Burst SRAM Cache Control Sequencer

This block generates the cycle-by-cycle control strobes and the index address for an external synchronous SRAM used as a cache. It drives five active-low strobes: address load, data output enable, data write, tag output enable and tag write. A requester asks for a four-beat read or a four-beat write over a valid/ready handshake. The sequencer then steps through the four beats and sets each strobe according to the SRAM timing style chosen by two configuration bits. Between transfers it leaves idle cycles, and it holds back a write that follows a read until the bus has had time to turn around.

The index address presented to the SRAM is cut to the configured cache size. An optional bank-enable rule puts the inverse of the top index bit on the next pin up. In the non-burst SRAM style the sequencer steps the low two address bits on each beat. In the burst style it presents the start address once and the SRAM advances the address on its own. The two configuration encodings with the alternate bit set are not supported. Selecting either one raises an error flag, holds every strobe inactive and refuses requests.

Top module: `cacheSeqTop`

## Requirements
- R1: While the synchronous active-high reset `rst` is high, the sequencer goes idle. In the first cycle after reset every strobe is high, `modeErr` is low, `bcAddr` is zero and `reqReady` is high when `cfgAlt` is low.
- R2: In every cycle with no beat in progress (a NOP cycle), all five strobes are high.
- R3: With `cfgAlt`=0, `cfgBurst`=0 selects SRAM type A and `cfgBurst`=1 selects SRAM type B. The type is captured when a request is accepted and applies to all four beats of that transfer.
- R4: A request accepted at a clock edge (`reqValid` and `reqReady` both high) produces beats 0, 1, 2 and 3 in the four cycles after that edge, with no gaps. The cycle after beat 3 is a NOP.
- R5: `loadN` is low on every beat for type A. For type B it is low on beat 0 only.
- R6: On read beats `dataOeN` is low on all four beats, `tagOeN` is low on beat 0 only, and `dataWrN` and `tagWrN` stay high.
- R7: On write beats `dataWrN` is low on all four beats, `dataOeN` and `tagOeN` stay high, and `tagWrN` is low on beat 0 only when `reqTagUpd` was high at acceptance.
- R8: `reqReady` is high only in NOP cycles. At least one NOP follows every transfer. A write that follows a read is accepted no earlier than the second NOP, so the read's last beat and the write's first beat are separated by at least two NOP cycles.
- R9: `reqIndex` is captured at acceptance. For type A, address bits [1:0] on beat k are the captured bits [1:0] plus k, modulo 4. For type B, and in NOP cycles, the captured address is presented unchanged.
- R10: The active index width n is `cfgIdxBits` clamped to the range 2 to `IDX_W`. Every `bcAddr` bit at position n or above is zero, except the one bit that R11 defines.
- R11: When `cfgBankEn` is high and n < `IDX_W`, `bcAddr[n]` is the complement of `bcAddr[n-1]`.
- R12: While `cfgAlt` is high, `reqReady` is low in the same cycle. `modeErr` follows `cfgAlt` one cycle later. While `modeErr` is high all strobes are high and any transfer in progress is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgBurst | input | 1 | SRAM type select: 0 = type A, 1 = type B |
| cfgAlt | input | 1 | Alternate-mode bit; 1 is an unsupported setting |
| cfgBankEn | input | 1 | Bank enable: complement of the top index bit on the next pin |
| cfgIdxBits | input | 5 | Number of active index bits (clamped to 2..IDX_W) |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request accepted when high together with reqValid |
| reqWrite | input | 1 | 1 = write burst, 0 = read burst |
| reqTagUpd | input | 1 | Write also updates the tag |
| reqIndex | input | IDX_W (20) | Cache index of the transfer |
| bcAddr | output | IDX_W (20) | SRAM index address pins |
| loadN | output | 1 | Address load strobe, active low |
| dataOeN | output | 1 | Data output enable, active low |
| dataWrN | output | 1 | Data write strobe, active low |
| tagOeN | output | 1 | Tag output enable, active low |
| tagWrN | output | 1 | Tag write strobe, active low |
| modeErr | output | 1 | Unsupported mode selected |

## Verification
The strobes and the address are decoded from registered beat state. They therefore show a beat in the cycle after the clock edge that accepted the request, or that advanced the beat. `reqReady` is combinational on the current inputs and state, so it is due in the same cycle. `modeErr` is due one edge after `cfgAlt` changes. The bench drives inputs just after the falling edge and compares `reqReady` a moment later. It compares strobes, address and flag at the next falling edge, against a cycle model that it advances once per rising edge. A separate counter measures the NOP gap between the last read-enable cycle and the start of each write, independently of the model.

// File: rtl/cacheSeqPkg.sv
package cacheSeqPkg;

  // Beat state handed from the sequencer to the strobe/address datapath.
  typedef struct packed {
    logic       active;   // a beat is in progress this cycle
    logic       isWrite;  // current transfer is a write
    logic       typeB;    // burst-style SRAM captured at acceptance
    logic       tagUpd;   // write carries a tag update
    logic [1:0] beat;     // beat number 0..3
    logic       capture;  // request accepted at the coming edge
    logic       quiet;    // unsupported mode: force strobes inactive
  } seqCtl_t;

endpackage

// File: rtl/cacheSeqCtrl.sv
module cacheSeqCtrl
  import cacheSeqPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    cfgBurst,
  input  logic    cfgAlt,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    reqTagUpd,
  output logic    reqReady,
  output seqCtl_t ctl
);

  localparam int BEATS    = 4;
  localparam int BEAT_W   = $clog2(BEATS);
  localparam int MIN_GAP  = 2;  // NOPs between a read and a following write
  localparam int GAP_W    = $clog2(MIN_GAP + 1);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);
  localparam logic [GAP_W-1:0]  GAP_FULL  = GAP_W'(MIN_GAP);

  logic              active;
  logic              isWrite;
  logic              typeB;
  logic              tagUpd;
  logic [BEAT_W-1:0] beat;
  logic [GAP_W-1:0]  nopCnt;
  logic              lastRead;
  logic              errFlag;
  logic              turnOk;
  logic              accept;

  // A write after a read must wait for the full gap; everything else may go.
  assign turnOk   = !(reqWrite && lastRead) || (nopCnt == GAP_FULL);
  assign reqReady = !active && !errFlag && !cfgAlt && turnOk;
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      isWrite  <= 1'b0;
      typeB    <= 1'b0;
      tagUpd   <= 1'b0;
      beat     <= '0;
      nopCnt   <= GAP_FULL;
      lastRead <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      errFlag <= cfgAlt;
      if (active) begin
        if (errFlag || beat == LAST_BEAT) begin
          active   <= 1'b0;
          beat     <= '0;
          nopCnt   <= GAP_W'(1);
          lastRead <= !isWrite;
        end else begin
          beat <= beat + BEAT_W'(1);
        end
      end else begin
        if (nopCnt != GAP_FULL) nopCnt <= nopCnt + GAP_W'(1);
        if (accept) begin
          active  <= 1'b1;
          beat    <= '0;
          isWrite <= reqWrite;
          typeB   <= cfgBurst;
          tagUpd  <= reqWrite && reqTagUpd;
        end
      end
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.active  = active;
    ctl.isWrite = isWrite;
    ctl.typeB   = typeB;
    ctl.tagUpd  = tagUpd;
    ctl.beat    = beat;
    ctl.capture = accept;
    ctl.quiet   = errFlag;
  end

  // R4: beats advance one per cycle with no gap.
  a_r4_beat_step: assert property (@(posedge clk) disable iff (rst)
    (active && !errFlag && beat != LAST_BEAT) |=> (active && beat == $past(beat) + BEAT_W'(1)));

  // R4: the cycle after the last beat is a NOP.
  a_r4_burst_end: assert property (@(posedge clk) disable iff (rst)
    (active && beat == LAST_BEAT) |=> !active);

  // R8: an accepted request always starts at beat 0 in the next cycle.
  a_r8_start_beat: assert property (@(posedge clk) disable iff (rst)
    accept |=> (active && beat == '0));

  // R12: an unsupported setting blocks a new transfer start.
  a_r12_no_start: assert property (@(posedge clk) disable iff (rst)
    (cfgAlt && !active) |=> !active);

endmodule

// File: rtl/cacheSeqPath.sv
module cacheSeqPath
  import cacheSeqPkg::*;
#(
  parameter int IDX_W = 20,
  parameter int SEL_W = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  seqCtl_t          ctl,
  input  logic             cfgBankEn,
  input  logic [SEL_W-1:0] cfgIdxBits,
  input  logic [IDX_W-1:0] reqIndex,
  output logic [IDX_W-1:0] bcAddr,
  output logic             loadN,
  output logic             dataOeN,
  output logic             dataWrN,
  output logic             tagOeN,
  output logic             tagWrN
);

  localparam int MIN_BITS = 2;  // the beat field always stays visible
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(IDX_W);
  localparam logic [SEL_W-1:0] MIN_SEL = SEL_W'(MIN_BITS);

  logic [IDX_W-1:0] baseIdx;
  logic [IDX_W-1:0] rawAddr;
  logic [SEL_W-1:0] effBits;
  logic [1:0]       beatOff;
  logic             drive;
  logic             firstBeat;
  logic [IDX_W-1:0] aboveTop;
  logic             topBit;

  always_ff @(posedge clk) begin
    if (rst) baseIdx <= '0;
    else if (ctl.capture) baseIdx <= reqIndex;
  end

  always_comb begin
    if (cfgIdxBits < MIN_SEL)      effBits = MIN_SEL;
    else if (cfgIdxBits > MAX_SEL) effBits = MAX_SEL;
    else                           effBits = cfgIdxBits;
  end

  // Type A steps the low bits each beat; type B lets the SRAM count.
  assign beatOff = (ctl.active && !ctl.typeB) ? ctl.beat : 2'd0;
  assign rawAddr = {baseIdx[IDX_W-1:2], baseIdx[1:0] + beatOff};

  genvar i;
  generate
    for (i = 0; i < IDX_W; i++) begin : g_pin
      if (i < MIN_BITS) begin : g_low
        assign bcAddr[i] = rawAddr[i];
      end else begin : g_high
        assign bcAddr[i] = (effBits > SEL_W'(i)) ? rawAddr[i] :
                           ((cfgBankEn && effBits == SEL_W'(i)) ? ~rawAddr[i-1] : 1'b0);
      end
    end
  endgenerate

  assign drive     = ctl.active && !ctl.quiet;
  assign firstBeat = (ctl.beat == 2'd0);

  assign loadN   = !(drive && (!ctl.typeB || firstBeat));
  assign dataOeN = !(drive && !ctl.isWrite);
  assign dataWrN = !(drive && ctl.isWrite);
  assign tagOeN  = !(drive && !ctl.isWrite && firstBeat);
  assign tagWrN  = !(drive && ctl.isWrite && ctl.tagUpd && firstBeat);

  assign aboveTop = bcAddr >> effBits;
  assign topBit   = bcAddr[effBits - SEL_W'(1)];

  // R2: no strobe moves outside a beat.
  a_r2_idle_high: assert property (@(posedge clk) disable iff (rst)
    !ctl.active |-> (loadN && dataOeN && dataWrN && tagOeN && tagWrN));

  // R7: read enable and write strobe never overlap.
  a_r7_no_clash: assert property (@(posedge clk) disable iff (rst)
    !(!dataOeN && !dataWrN));

  // R10: pins above the cache size stay low without bank enable.
  a_r10_zero_above: assert property (@(posedge clk) disable iff (rst)
    !cfgBankEn |-> (aboveTop == '0));

  // R11: bank pin carries the complement of the top index bit.
  a_r11_bank_pin: assert property (@(posedge clk) disable iff (rst)
    (cfgBankEn && effBits < MAX_SEL) |-> (aboveTop == {{(IDX_W-1){1'b0}}, ~topBit}));

endmodule

// File: rtl/cacheSeqTop.sv
module cacheSeqTop
  import cacheSeqPkg::*;
#(
  parameter int IDX_W = 20,
  localparam int SEL_W = $clog2(IDX_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgBurst,
  input  logic             cfgAlt,
  input  logic             cfgBankEn,
  input  logic [SEL_W-1:0] cfgIdxBits,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqWrite,
  input  logic             reqTagUpd,
  input  logic [IDX_W-1:0] reqIndex,
  output logic [IDX_W-1:0] bcAddr,
  output logic             loadN,
  output logic             dataOeN,
  output logic             dataWrN,
  output logic             tagOeN,
  output logic             tagWrN,
  output logic             modeErr
);

  seqCtl_t seqCtl;

  cacheSeqCtrl uCtrl (
    .clk       (clk),
    .rst       (rst),
    .cfgBurst  (cfgBurst),
    .cfgAlt    (cfgAlt),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqTagUpd (reqTagUpd),
    .reqReady  (reqReady),
    .ctl       (seqCtl)
  );

  cacheSeqPath #(.IDX_W(IDX_W), .SEL_W(SEL_W)) uPath (
    .clk        (clk),
    .rst        (rst),
    .ctl        (seqCtl),
    .cfgBankEn  (cfgBankEn),
    .cfgIdxBits (cfgIdxBits),
    .reqIndex   (reqIndex),
    .bcAddr     (bcAddr),
    .loadN      (loadN),
    .dataOeN    (dataOeN),
    .dataWrN    (dataWrN),
    .tagOeN     (tagOeN),
    .tagWrN     (tagWrN)
  );

  assign modeErr = seqCtl.quiet;

  // R8: after a read enable cycle, the next two cycles carry no write strobe.
  a_r8_turn_gap1: assert property (@(posedge clk) disable iff (rst)
    !dataOeN |=> dataWrN);
  a_r8_turn_gap2: assert property (@(posedge clk) disable iff (rst)
    !dataOeN |=> ##1 dataWrN);

  // R12: error flag silences the bus and the request port.
  a_r12_err_quiet: assert property (@(posedge clk) disable iff (rst)
    modeErr |-> (loadN && dataOeN && dataWrN && tagOeN && tagWrN && !reqReady));

endmodule

// File: tb/tb_cacheSeqTop.sv
module tb_cacheSeqTop;

  localparam int CLK_PERIOD = 10;
  localparam int IDX_W      = 20;
  localparam int SEL_W      = 5;
  localparam int N_CYCLES   = 6000;

  logic             clk = 1'b0;
  logic             rst;
  logic             cfgBurst, cfgAlt, cfgBankEn;
  logic [SEL_W-1:0] cfgIdxBits;
  logic             reqValid, reqReady, reqWrite, reqTagUpd;
  logic [IDX_W-1:0] reqIndex, bcAddr;
  logic             loadN, dataOeN, dataWrN, tagOeN, tagWrN, modeErr;

  int checks = 0;
  int failures = 0;

  // reference model state
  logic             mActive, mWrite, mTypeB, mTag, mLastRead, mErr;
  logic [1:0]       mBeat;
  int               mNop;
  logic [IDX_W-1:0] mBase;
  logic             expReady;
  int               cyc = 0;
  int               lastOeCyc = -100;
  logic             prevWrN = 1'b1;

  always #(CLK_PERIOD/2) clk = ~clk;

  cacheSeqTop #(.IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst), .cfgBurst(cfgBurst), .cfgAlt(cfgAlt), .cfgBankEn(cfgBankEn),
    .cfgIdxBits(cfgIdxBits), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqTagUpd(reqTagUpd), .reqIndex(reqIndex), .bcAddr(bcAddr), .loadN(loadN),
    .dataOeN(dataOeN), .dataWrN(dataWrN), .tagOeN(tagOeN), .tagWrN(tagWrN), .modeErr(modeErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] expAddr(input logic [IDX_W-1:0] base, input logic [1:0] off,
                                                input logic [SEL_W-1:0] bits, input logic bank);
    int n;
    logic [IDX_W-1:0] a;
    n = int'(bits);
    if (n < 2) n = 2;
    if (n > IDX_W) n = IDX_W;
    a = base;
    a[1:0] = base[1:0] + off;
    for (int i = 0; i < IDX_W; i++) if (i >= n) a[i] = 1'b0;
    if (bank && n < IDX_W) a[n] = ~a[n-1];
    return a;
  endfunction

  task automatic checkOutputs(input bit first);
    logic drv;
    logic [1:0] off;
    drv = mActive && !mErr;
    off = (mActive && !mTypeB) ? mBeat : 2'd0;
    if (first) begin
      chk("R1 strobes", {27'd0, loadN, dataOeN, dataWrN, tagOeN, tagWrN}, 32'h1f);
      chk("R1 modeErr", 32'(modeErr), 32'd0);
      chk("R1 bcAddr", 32'(bcAddr), 32'd0);
    end else if (!mActive) begin
      chk("R2 idle strobes", {27'd0, loadN, dataOeN, dataWrN, tagOeN, tagWrN}, 32'h1f);
    end else if (mErr) begin
      chk("R12 quiet strobes", {27'd0, loadN, dataOeN, dataWrN, tagOeN, tagWrN}, 32'h1f);
    end else begin
      chk("R3 R5 load", 32'(loadN), 32'(!(drv && (!mTypeB || mBeat == 2'd0))));
      chk("R4 R6 dataOe", 32'(dataOeN), 32'(!(drv && !mWrite)));
      chk("R6 tagOe", 32'(tagOeN), 32'(!(drv && !mWrite && mBeat == 2'd0)));
      chk("R4 R7 dataWr", 32'(dataWrN), 32'(!(drv && mWrite)));
      chk("R7 tagWr", 32'(tagWrN), 32'(!(drv && mWrite && mTag && mBeat == 2'd0)));
    end
    chk("R9 R10 R11 bcAddr", 32'(bcAddr), 32'(expAddr(mBase, off, cfgIdxBits, cfgBankEn)));
    chk("R12 modeErr", 32'(modeErr), 32'(mErr));
    // R8: independent gap measurement from the pins
    if (!dataOeN) lastOeCyc = cyc;
    if (!dataWrN && prevWrN) chk("R8 read-to-write gap ok", 32'(cyc - lastOeCyc >= 3), 32'd1);
    prevWrN = dataWrN;
  endtask

  task automatic stepModel();
    if (mActive) begin
      if (mErr || mBeat == 2'd3) begin
        mActive = 1'b0; mBeat = 2'd0; mNop = 1; mLastRead = !mWrite;
      end else mBeat = mBeat + 2'd1;
    end else begin
      if (mNop != 2) mNop++;
      if (reqValid && expReady) begin
        mActive = 1'b1; mBeat = 2'd0; mWrite = reqWrite; mTypeB = cfgBurst;
        mTag = reqWrite && reqTagUpd; mBase = reqIndex;
      end
    end
    mErr = cfgAlt;
  endtask

  initial begin
    int altTimer;
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    altTimer = 0;
    rst = 1'b1; cfgBurst = 1'b0; cfgAlt = 1'b0; cfgBankEn = 1'b0; cfgIdxBits = 5'd20;
    reqValid = 1'b0; reqWrite = 1'b0; reqTagUpd = 1'b0; reqIndex = '0;
    mActive = 0; mWrite = 0; mTypeB = 0; mTag = 0; mLastRead = 0; mErr = 0;
    mBeat = 0; mNop = 2; mBase = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    for (int c = 0; c < N_CYCLES; c++) begin
      @(negedge clk);
      cyc = c;
      checkOutputs(c == 0);
      // stimulus: directed opening, random afterwards
      if (c < 40) begin
        reqValid  = 1'b1;
        reqWrite  = (c >= 6);           // read then immediate write: turnaround
        reqTagUpd = (c < 20);
        cfgBurst  = (c >= 12);          // type A then type B
        cfgIdxBits = (c < 20) ? 5'd0 : 5'd31;  // both clamp ends
        cfgBankEn = (c >= 25);
        reqIndex  = IDX_W'(32'hABCDE + c);
      end else begin
        reqValid  = ($urandom % 2) == 0;
        reqWrite  = ($urandom % 2) == 0;
        reqTagUpd = ($urandom % 2) == 0;
        reqIndex  = IDX_W'($urandom);
        if (($urandom % 100) == 0) cfgBurst = ~cfgBurst;
        if (($urandom % 50) == 0) cfgIdxBits = SEL_W'($urandom % 32);
        if (($urandom % 50) == 0) cfgBankEn = ~cfgBankEn;
        if (altTimer > 0) altTimer--;
        else if (($urandom % 300) == 0) altTimer = 3 + int'($urandom % 4);
        cfgAlt = (altTimer > 0);
      end
      #1;
      expReady = !mActive && !mErr && !cfgAlt && (!(reqWrite && mLastRead) || mNop == 2);
      chk(c == 0 ? "R1 ready" : (cfgAlt ? "R12 ready" : "R8 ready"), 32'(reqReady), 32'(expReady));
      @(posedge clk);
      stepModel();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule